// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block measures the rotation speed of a fan from its tachometer signal. A 16-bit counter counts down on a prescaled clock. The time between two rising edges of the tach signal is recorded as a count value. Software turns that value into a speed. If the fan has stalled, no edge arrives. In that case the counter reaches a programmable compare value, and the block raises a separate stall indication instead of a capture.

Software prepares a measurement with a fixed sequence. It stops the counter, clears the pending flags and loads the counter with all ones. It then programs the stall compare value and the prescale divider, and sets the run bit. The first synchronized rising edge reloads the counter and restarts the prescale phase. The second rising edge latches the counter into the capture register. After either a capture or a stall, the counter stays frozen until software writes it again. A single interrupt output is active while any pending flag is set whose enable bit is also set.

The register port is synchronous. It takes a halfword index and two byte-lane enables, so both byte and halfword accesses are possible. Reads are combinational.

Top module: `fan_tach_timer`

## Requirements
- R1: After reset the registers read as follows: counter 0xFFFF, capture 0xFFFF, prescale 0, control 0, status 0, enable 0 and stall compare 0. The interrupt output is low.
- R2: Each register sits at a fixed halfword index:
  - counter at 0 (byte offset 0x00)
  - capture at 1 (0x02)
  - prescale at 4 (0x08)
  - control at 5 (0x0A)
  - status at 7 (0x0E)
  - clear at 8 (0x10)
  - enable at 9 (0x12)
  - stall compare at 10 (0x14)
  
  Lane enable bit 0 writes the low byte and bit 1 writes the high byte. Prescale holds 8 bits, control holds bit 0, and enable holds 6 bits. The clear register always reads 0.
- R3: While control bit 0 is 0, the counter holds its value. While control bit 0 is 1, the counter decrements by one every prescale+1 clocks, counted from the write that set the bit.
- R4: The tach input passes through two synchronizer flops. The first rising edge after start reloads the counter to 0xFFFF. For two rising edges D clocks apart, the second edge latches 0xFFFF − floor((D−1)/(prescale+1)) into the capture register.
- R5: A capture sets status bit 0 and freezes the counter at the captured value. Further tach edges have no effect until software writes the counter.
- R6: If the running counter equals the stall compare value before a capture, status bit 4 is set. The counter stays at the compare value and the capture register is unchanged.
- R7: Writing a 1 to a bit of the clear register clears that status bit. Writes to the status index change nothing.
- R8: The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R9: Only rising tach edges count. A falling edge after start neither reloads the counter nor captures.
- R10: Clearing control bit 0 discards a first edge already seen. After a restart, two new rising edges are needed for a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_hw_addr | input | 4 | Halfword register index |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 2 | Byte lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| tach_in | input | 1 | Fan tachometer pulse input (asynchronous) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default widths: a 16-bit counter, an 8-bit prescaler, six pending bits and a two-flop synchronizer. It programs a stall compare value just below 0xFFFF, which reaches the stall path within tens of cycles, and it also runs one measurement against the full 0x5000 span. The pulse-gap table mixes dividers of 0 and 255 with gaps that are not multiples of the divider, which exercises the floor rounding of the capture value.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int BUS_W  = 16;
  localparam int IDX_W  = 4;
  localparam int PEND_W = 6;
  localparam int CAP_BIT = 0;
  localparam int TMO_BIT = 4;

  // halfword indices (byte offset / 2)
  localparam logic [IDX_W-1:0] IX_CNT = 4'h0;
  localparam logic [IDX_W-1:0] IX_CAP = 4'h1;
  localparam logic [IDX_W-1:0] IX_PRS = 4'h4;
  localparam logic [IDX_W-1:0] IX_CTL = 4'h5;
  localparam logic [IDX_W-1:0] IX_STA = 4'h7;
  localparam logic [IDX_W-1:0] IX_CLR = 4'h8;
  localparam logic [IDX_W-1:0] IX_IEN = 4'h9;
  localparam logic [IDX_W-1:0] IX_TMO = 4'hA;

  function automatic logic [BUS_W-1:0] lane_merge(
    input logic [BUS_W-1:0] old_v,
    input logic [BUS_W-1:0] new_v,
    input logic [1:0]       be);
    logic [BUS_W-1:0] r;
    r = old_v;
    if (be[0]) r[7:0]        = new_v[7:0];
    if (be[1]) r[BUS_W-1:8]  = new_v[BUS_W-1:8];
    return r;
  endfunction
endpackage

// File: rtl/fan_tach_edge.sv
module fan_tach_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R9
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/fan_tach_prescale.sv
module fan_tach_prescale #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pc <= '0;
    else if (!run || restart)  pc <= '0;
    else if (pc == div)        pc <= '0;
    else                       pc <= pc + 1'b1;
  end

  assign tick = run && (pc == div);

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && !restart) |=> !tick);
endmodule

// File: rtl/fan_tach_core.sv
module fan_tach_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         rise,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cap_wr,
  input  logic [W-1:0] cap_wdata,
  input  logic [W-1:0] tmo,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cap,
  output logic         ev_capture,
  output logic         ev_timeout,
  output logic         ev_rearm
);
  logic armed, done, active, step;

  assign active     = run && !done;
  assign ev_rearm   = active && rise && !armed;
  assign ev_capture = active && rise && armed;
  assign ev_timeout = active && !rise && (cnt == tmo);
  assign step       = active && !rise && tick && (cnt != tmo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      done  <= 1'b0;
      cnt   <= '1;
      cap   <= '1;
    end else begin
      if (!run || cnt_wr)  armed <= 1'b0;
      else if (ev_rearm)   armed <= 1'b1;

      if (cnt_wr)                         done <= 1'b0;
      else if (ev_capture || ev_timeout)  done <= 1'b1;

      if (cnt_wr)         cnt <= cnt_wdata;
      else if (ev_rearm)  cnt <= '1;
      else if (step)      cnt <= cnt - 1'b1;

      if (cap_wr)           cap <= cap_wdata;
      else if (ev_capture)  cap <= cnt;
    end
  end

  // R5
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_capture && !cap_wr) |=> cap == $past(cnt));
  // R5
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_capture && !cnt_wr) |=> !ev_capture);
  // R6
  tmo_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_timeout && !cnt_wr) |=> cnt == $past(cnt));
  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !ev_rearm) |=> (cnt == $past(cnt) || cnt == W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/fan_tach_timer.sv
module fan_tach_timer
  import fan_tach_pkg::*;
#(
  parameter int PRS_W     = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] bus_hw_addr,
  input  logic             bus_we,
  input  logic [1:0]       bus_be,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             tach_in,
  output logic             irq
);
  logic [PRS_W-1:0]  prsc;
  logic              run;
  logic [PEND_W-1:0] pend, ien, clr_mask, set_vec;
  logic [BUS_W-1:0]  tmo, cnt, cap;
  logic              rise, tick, ev_capture, ev_timeout, ev_rearm;
  logic              wr_cnt, wr_cap, wr_prs, wr_ctl, wr_clr, wr_ien, wr_tmo;

  assign wr_cnt = bus_we && bus_hw_addr == IX_CNT;
  assign wr_cap = bus_we && bus_hw_addr == IX_CAP;
  assign wr_prs = bus_we && bus_hw_addr == IX_PRS && bus_be[0];
  assign wr_ctl = bus_we && bus_hw_addr == IX_CTL && bus_be[0];
  assign wr_clr = bus_we && bus_hw_addr == IX_CLR && bus_be[0];
  assign wr_ien = bus_we && bus_hw_addr == IX_IEN && bus_be[0];
  assign wr_tmo = bus_we && bus_hw_addr == IX_TMO;

  fan_tach_edge #(.STAGES(SYNC_STG)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(tach_in), .rise(rise));

  fan_tach_prescale #(.PW(PRS_W)) u_prs (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(ev_rearm),
    .div(prsc), .tick(tick));

  fan_tach_core #(.W(BUS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .rise(rise),
    .cnt_wr(wr_cnt), .cnt_wdata(lane_merge(cnt, bus_wdata, bus_be)),
    .cap_wr(wr_cap), .cap_wdata(lane_merge(cap, bus_wdata, bus_be)),
    .tmo(tmo), .cnt(cnt), .cap(cap),
    .ev_capture(ev_capture), .ev_timeout(ev_timeout), .ev_rearm(ev_rearm));

  always_comb begin
    set_vec          = '0;
    set_vec[CAP_BIT] = ev_capture;
    set_vec[TMO_BIT] = ev_timeout;
    clr_mask         = wr_clr ? bus_wdata[PEND_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prsc <= '0;
      run  <= 1'b0;
      pend <= '0;
      ien  <= '0;
      tmo  <= '0;
    end else begin
      if (wr_prs) prsc <= bus_wdata[PRS_W-1:0];
      if (wr_ctl) run  <= bus_wdata[0];
      if (wr_ien) ien  <= bus_wdata[PEND_W-1:0];
      if (wr_tmo) tmo  <= lane_merge(tmo, bus_wdata, bus_be);
      pend <= (pend & ~clr_mask) | set_vec;
    end
  end

  assign irq = |(pend & ien);

  always_comb begin
    case (bus_hw_addr)
      IX_CNT:  bus_rdata = cnt;
      IX_CAP:  bus_rdata = cap;
      IX_PRS:  bus_rdata = BUS_W'(prsc);
      IX_CTL:  bus_rdata = BUS_W'(run);
      IX_STA:  bus_rdata = BUS_W'(pend);
      IX_IEN:  bus_rdata = BUS_W'(ien);
      IX_TMO:  bus_rdata = tmo;
      default: bus_rdata = '0;
    endcase
  end

  // R7
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask[CAP_BIT] && !ev_capture) |=> !pend[CAP_BIT]);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);
endmodule

// File: tb/sim_fan_tach_timer.sv
module sim_fan_tach_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_hw_addr = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_be = 2'b11;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tach_in = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  fan_tach_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_hw_addr(bus_hw_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tach_in(tach_in), .irq(irq));

  // {prescale, gap in clocks, expected capture}
  localparam logic [39:0] VEC [7] = '{
    {8'd0,   16'd5,   16'hFFFB},
    {8'd0,   16'd20,  16'hFFEC},
    {8'd1,   16'd10,  16'hFFFB},
    {8'd3,   16'd40,  16'hFFF6},
    {8'd9,   16'd101, 16'hFFF5},
    {8'd2,   16'd7,   16'hFFFD},
    {8'd255, 16'd600, 16'hFFFD}
  };

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_hw_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 2'b11;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_hw_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_pair(input int gap);
    @(negedge clk);
    tach_in = 1'b1; waitc(2); tach_in = 1'b0; waitc(gap - 2);
    tach_in = 1'b1; waitc(2); tach_in = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got=hung expected=done");
    finish_run();
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    // R1 reset values
    rd(4'h0, rv); check("R1 cnt", rv, 16'hFFFF);
    rd(4'h1, rv); check("R1 cap", rv, 16'hFFFF);
    rd(4'h4, rv); check("R1 prs", rv, 0);
    rd(4'h5, rv); check("R1 ctl", rv, 0);
    rd(4'h7, rv); check("R1 sta", rv, 0);
    rd(4'h9, rv); check("R1 ien", rv, 0);
    rd(4'hA, rv); check("R1 tmo", rv, 0);
    check("R1 irq", irq, 0);

    // R2 lanes and widths
    wr(4'hA, 16'h1234, 2'b11); rd(4'hA, rv); check("R2 tmo hw", rv, 16'h1234);
    wr(4'hA, 16'hAB00, 2'b10); rd(4'hA, rv); check("R2 tmo hi byte", rv, 16'hAB34);
    wr(4'h4, 16'hFFFF, 2'b11); rd(4'h4, rv); check("R2 prs width", rv, 16'h00FF);
    wr(4'h5, 16'hFFFE, 2'b11); rd(4'h5, rv); check("R2 ctl bit0", rv, 0);
    wr(4'h9, 16'hFFFF, 2'b11); rd(4'h9, rv); check("R2 ien width", rv, 16'h003F);
    wr(4'h9, 16'h0000, 2'b11);
    wr(4'h0, 16'h5A5A, 2'b11); rd(4'h0, rv); check("R2 cnt", rv, 16'h5A5A);
    rd(4'h8, rv); check("R2 clr reads 0", rv, 0);

    // R3 hold when stopped, step when running
    wr(4'hA, 16'h0000, 2'b11);
    wr(4'h0, 16'h0100, 2'b11);
    waitc(10); rd(4'h0, rv); check("R3 hold stopped", rv, 16'h0100);
    wr(4'h4, 16'h0003, 2'b11);
    wr(4'h5, 16'h0001, 2'b11);
    waitc(20); rd(4'h0, rv); check("R3 divide by 4", rv, 16'h00FB);

    // R6 stall detection
    wr(4'h5, 0, 2'b11); wr(4'h8, 16'h3F, 2'b11);
    wr(4'h0, 16'hFFFF, 2'b11); wr(4'h1, 16'h1234, 2'b11);
    wr(4'hA, 16'hFFF0, 2'b11); wr(4'h4, 0, 2'b11); wr(4'h5, 1, 2'b11);
    waitc(40);
    rd(4'h7, rv); check("R6 stall flag", rv, 16'h0010);
    rd(4'h0, rv); check("R6 cnt frozen", rv, 16'hFFF0);
    rd(4'h1, rv); check("R6 cap kept", rv, 16'h1234);
    // R8 interrupt gating
    check("R8 irq masked", irq, 0);
    wr(4'h9, 16'h0010, 2'b11); #1 check("R8 irq enabled", irq, 1);
    wr(4'h9, 16'h0001, 2'b11); #1 check("R8 irq other bit", irq, 0);
    // R7 status read-only, clear by mask
    wr(4'h7, 16'h003F, 2'b11); rd(4'h7, rv); check("R7 sta write ignored", rv, 16'h0010);
    wr(4'h8, 16'h0010, 2'b11); rd(4'h7, rv); check("R7 cleared", rv, 0);
    wr(4'h9, 0, 2'b11);

    // R4 / R5 table
    for (int i = 0; i < 7; i++) begin
      wr(4'h5, 0, 2'b11); wr(4'h8, 16'h3F, 2'b11);
      wr(4'h0, 16'hFFFF, 2'b11); wr(4'h1, 16'hFFFF, 2'b11);
      wr(4'hA, 16'hAFFF, 2'b11); wr(4'h4, 16'(VEC[i][39:32]), 2'b11);
      wr(4'h5, 1, 2'b11);
      waitc(3);
      pulse_pair(int'(VEC[i][31:16]));
      waitc(6);
      rd(4'h1, rv); check($sformatf("R4 capture vec%0d", i), rv, VEC[i][15:0]);
      rd(4'h0, rv); check($sformatf("R5 cnt frozen vec%0d", i), rv, VEC[i][15:0]);
      rd(4'h7, rv); check($sformatf("R5 sta vec%0d", i), rv, 1);
    end

    // R5 later edges ignored
    pulse_pair(10); waitc(6);
    rd(4'h1, rv); check("R5 later edge cap", rv, 16'hFFFD);
    rd(4'h0, rv); check("R5 later edge cnt", rv, 16'hFFFD);

    // R9 / R10 restart and falling edge
    wr(4'h5, 0, 2'b11);
    @(negedge clk); tach_in = 1'b1; waitc(4);
    wr(4'h8, 16'h3F, 2'b11); wr(4'h0, 16'hFFFF, 2'b11);
    wr(4'h1, 16'h4321, 2'b11); wr(4'h4, 0, 2'b11); wr(4'h5, 1, 2'b11);
    waitc(4); tach_in = 1'b0; waitc(4);
    tach_in = 1'b1; waitc(4); tach_in = 1'b0; waitc(6);
    rd(4'h7, rv); check("R9 fall plus one rise no capture", rv, 0);
    rd(4'h1, rv); check("R10 cap untouched", rv, 16'h4321);
    tach_in = 1'b1; waitc(6); tach_in = 1'b0;
    rd(4'h7, rv); check("R10 second rise captures", rv, 1);
    rd(4'h1, rv); check("R10 capture value", rv, 16'hFFF6);

    // R6 full stall span
    wr(4'h5, 0, 2'b11); wr(4'h8, 16'h3F, 2'b11);
    wr(4'h0, 16'hFFFF, 2'b11); wr(4'hA, 16'hAFFF, 2'b11);
    wr(4'h5, 1, 2'b11);
    waitc(16'h5000 + 20);
    rd(4'h7, rv); check("R6 full span flag", rv, 16'h0010);
    rd(4'h0, rv); check("R6 full span cnt", rv, 16'hAFFF);

    finish_run();
  end
endmodule